// File: doc/BRIEF.md
# Two-Device Reset Presence Coordinator

This block runs on the primary device of a bus shared by two devices. After each reset or diagnostic request it decides whether a secondary device is attached, and whether that device passed its own self-test. It reports a one-byte diagnostic result and a completion flag. It does this by watching two open-drain sideband lines, both active low. The presence line (`presence_n`) shows that the secondary device exists. The pass line (`pass_n`) shows that the secondary device completed its self-test without error.

A request is a one-cycle `start` pulse, with `req_kind` giving the type of request. The encoding is 0 = power-on reset, 1 = hardware reset, 2 = software reset, 3 = diagnostic command. The type decides which lines the block examines and how long it waits for each. All waits are counted in pulses of `ms_tick`, and each limit is a parameter.

The local self-test result arrives on `local_code` with the `start` pulse and is captured at that moment. The block reports it as received, with bit 7 set when the secondary device failed or did not answer in time. The normal codes are 0x01 for no error and 0x02, 0x03 or 0x05 for local faults.

Top module: `reset_presence_seq`

## Requirements
- R1: After reset, `done` is 0, `diag_code` is 0x00 and `slave_present` is 0.
- R2: On a power-on reset (kind 0) or a hardware reset (kind 1), `slave_present` is cleared. If `presence_n` is low in any cycle before or during the `PRES_MS`-th tick, a secondary device is recorded as present. Otherwise the block finishes with `slave_present` = 0 and `diag_code` equal to the captured local code.
- R3: After a power-on or hardware reset that found a secondary device, the block waits for `pass_n` to go low. The wait ends at the `RST_MS`-th tick, counted from the cycle in which presence was found.
- R4: On a software reset (kind 2), `presence_n` is not examined and `slave_present` keeps the value it had before the request.
- R5: On a software reset with a secondary device present, the block waits for `pass_n` up to the `RST_MS`-th tick. With no secondary device present, it finishes in the cycle after `start` and reports the local code.
- R6: On a diagnostic command (kind 3), `presence_n` is ignored and `slave_present` is kept. With a secondary device present, the block waits for `pass_n` up to the `DIAG_MS`-th tick. Without one, it finishes in the cycle after `start`.
- R7: When `pass_n` is seen low, `diag_code` equals the captured local code. When the wait runs out, `diag_code` is the local code with bit 7 set. For example, 0x01 becomes 0x81 and 0x03 becomes 0x83.
- R8: A `start` of any kind abandons any sequence in progress and restarts from idle. Once `done` is 1, it stays 1 until the next `start`.
- R9: A line seen low in the same cycle as the final tick of its window counts as seen, not as a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request pulse |
| req_kind | input | 2 | 0 power-on, 1 hardware, 2 software, 3 diagnostic |
| ms_tick | input | 1 | One-cycle millisecond pulse |
| local_code | input | 8 | Local self-test code, captured on `start` |
| presence_n | input | 1 | Sampled presence line, active low |
| pass_n | input | 1 | Sampled pass line, active low |
| done | output | 1 | Sequence complete |
| diag_code | output | 8 | Diagnostic result, valid while `done` is 1 |
| slave_present | output | 1 | Secondary device detected |

## Verification
The bench targets the window edges. It drives each line low exactly on the last tick of its window and one tick later. A design that let the timeout win at that tick would report an absent device or set bit 7 for a device that answered in time.

It holds the presence line low during software resets and diagnostic commands that follow a reset with no secondary device. A design that looked at the line in those cases would invent a device and wait for a pass signal that never comes.

It interrupts a power-on sequence partway with a new request. A design that did not restart would report a result from the abandoned sequence.

// File: rtl/reset_presence_seq.sv
module reset_presence_seq #(
  parameter int PRES_MS = 450,
  parameter int RST_MS  = 31000,
  parameter int DIAG_MS = 6000,
  localparam int MAXL = (RST_MS > DIAG_MS) ? ((RST_MS > PRES_MS) ? RST_MS : PRES_MS)
                                           : ((DIAG_MS > PRES_MS) ? DIAG_MS : PRES_MS),
  localparam int CW = $clog2(MAXL + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] req_kind,
  input  logic       ms_tick,
  input  logic [7:0] local_code,
  input  logic       presence_n,
  input  logic       pass_n,
  output logic       done,
  output logic [7:0] diag_code,
  output logic       slave_present
);
  localparam logic [1:0] K_PWR = 2'd0, K_HW = 2'd1, K_SW = 2'd2, K_DIAG = 2'd3;
  typedef enum logic [1:0] {S_IDLE, S_PRES, S_PASS} st_t;

  st_t         st;
  logic [CW-1:0] cnt, lim;
  logic [7:0]  loc_q;
  logic        tmo;

  assign tmo = ms_tick && (cnt == lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      lim <= '0;
      loc_q <= '0;
      done <= 1'b0;
      diag_code <= 8'h00;
      slave_present <= 1'b0;
    end else if (start) begin
      done <= 1'b0;
      loc_q <= local_code;
      cnt <= '0;
      st <= S_IDLE;
      if (req_kind == K_PWR || req_kind == K_HW) begin
        slave_present <= 1'b0;
        lim <= CW'(PRES_MS);
        st <= S_PRES;
      end else if (slave_present) begin
        lim <= (req_kind == K_SW) ? CW'(RST_MS) : CW'(DIAG_MS);
        st <= S_PASS;
      end else begin
        diag_code <= local_code;
        done <= 1'b1;
      end
    end else begin
      case (st)
        S_PRES:
          if (!presence_n) begin
            slave_present <= 1'b1;
            lim <= CW'(RST_MS);
            cnt <= '0;
            st <= S_PASS;
          end else if (tmo) begin
            diag_code <= loc_q;
            done <= 1'b1;
            st <= S_IDLE;
          end else if (ms_tick) cnt <= cnt + CW'(1);
        S_PASS:
          if (!pass_n) begin
            diag_code <= loc_q;
            done <= 1'b1;
            st <= S_IDLE;
          end else if (tmo) begin
            diag_code <= loc_q | 8'h80;
            done <= 1'b1;
            st <= S_IDLE;
          end else if (ms_tick) cnt <= cnt + CW'(1);
        default: ;
      endcase
    end
  end

  a_r2_hw_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start && (req_kind == K_PWR || req_kind == K_HW) |=> !slave_present && !done);
  a_r2_presence_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slave_present) |-> $past(st) == S_PRES && !$past(presence_n));
  a_r4_sw_keeps_presence: assert property (@(posedge clk) disable iff (!rst_n)
    start && req_kind == K_SW |=> slave_present == $past(slave_present));
  a_r6_diag_keeps_presence: assert property (@(posedge clk) disable iff (!rst_n)
    start && req_kind == K_DIAG |=> slave_present == $past(slave_present));
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  a_r7_absent_no_fail_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && !slave_present |-> diag_code == loc_q);
endmodule

// File: tb/reset_presence_seq_tb.sv
module reset_presence_seq_tb_top;
  localparam int TP = 6, TR = 20, TG = 10;
  logic clk = 0, rst_n = 0, start = 0, ms_tick = 0, presence_n = 1, pass_n = 1;
  logic [1:0] req_kind = 0;
  logic [7:0] local_code = 0;
  logic done, slave_present;
  logic [7:0] diag_code;
  int checks = 0, errors = 0;
  bit model_pres = 0;

  always #2 clk = ~clk;

  reset_presence_seq #(.PRES_MS(TP), .RST_MS(TR), .DIAG_MS(TG)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_kind(req_kind), .ms_tick(ms_tick),
    .local_code(local_code), .presence_n(presence_n), .pass_n(pass_n),
    .done(done), .diag_code(diag_code), .slave_present(slave_present));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // returns {present, code}
  function automatic logic [8:0] expect_case(int kind, logic [7:0] loc, int a, int p, bit prev);
    bit pres; bit pass;
    if (kind <= 1) begin
      pres = (a < TP);
      if (!pres) return {1'b0, loc};
      pass = (p <= a + TR);
    end else begin
      pres = prev;
      if (!pres) return {1'b0, loc};
      pass = (p <= ((kind == 2) ? TR : TG) - 1);
    end
    return {1'b1, pass ? loc : (loc | 8'h80)};
  endfunction

  task automatic do_start(int kind, logic [7:0] loc);
    @(negedge clk);
    start = 1; req_kind = 2'(kind); local_code = loc;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run_steps(int a, int p, int maxn);
    for (int t = 0; t < maxn && !done; t++) begin
      presence_n = !(t >= a);
      pass_n = !(t >= p);
      ms_tick = 1;
      @(negedge clk);
      ms_tick = 0;
      @(negedge clk);
    end
    presence_n = 1; pass_n = 1;
  endtask

  task automatic one_case(string tag, int kind, logic [7:0] loc, int a, int p);
    logic [8:0] e;
    e = expect_case(kind, loc, a, p, model_pres);
    do_start(kind, loc);
    run_steps(a, p, 80);
    check({tag, " done"}, done, 1);
    check({tag, " code"}, diag_code, e[7:0]);
    check({tag, " present"}, slave_present, e[8]);
    model_pres = e[8];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] codes [4];
    int unused;
    codes[0] = 8'h01; codes[1] = 8'h02; codes[2] = 8'h03; codes[3] = 8'h05;
    unused = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    check("R1 done", done, 0);
    check("R1 code", diag_code, 0);
    check("R1 present", slave_present, 0);
    rst_n = 1;

    one_case("R2 pwr absent", 0, 8'h01, 100, 100);
    one_case("R4 sw ignores presence", 2, 8'h01, 0, 100);
    one_case("R6 diag ignores presence", 3, 8'h02, 0, 0);
    one_case("R9 R2 presence on last tick", 1, 8'h01, TP - 1, TP + 3);
    one_case("R2 presence one tick late", 1, 8'h01, TP, 0);
    one_case("R3 R9 pass on last tick", 0, 8'h03, 2, 2 + TR);
    one_case("R3 R7 pass one tick late", 0, 8'h01, 2, 3 + TR);
    one_case("R5 R9 sw pass last tick", 2, 8'h05, 100, TR - 1);
    one_case("R5 R7 sw timeout", 2, 8'h01, 100, TR);
    one_case("R6 R9 diag pass last tick", 3, 8'h01, 100, TG - 1);
    one_case("R6 R7 diag timeout", 3, 8'h02, 0, TG);

    do_start(0, 8'h01);
    check("R8 start clears done", done, 0);
    run_steps(100, 100, 3);
    do_start(2, 8'h03);
    check("R8 restart done", done, 1);
    check("R8 restart code", diag_code, 8'h03);
    check("R8 restart present", slave_present, 0);
    model_pres = 0;
    @(negedge clk);
    check("R8 done held", done, 1);

    for (int i = 0; i < 30; i++) begin
      int kind, a, p;
      kind = int'($urandom_range(3));
      a = int'($urandom_range(TP + 3));
      p = int'($urandom_range(a + TR + 3));
      one_case("R7 random", kind, codes[$urandom_range(3)], a, p);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule